// File: doc/BRIEF.md
# Write-Only I2C Target with Strap-Selected Address

This block receives control bytes from an I2C controller. A fast system clock oversamples SCL and SDA. Both lines go through a two-flop synchronizer and a glitch filter before any edge is decoded. The block recognises START and STOP, shifts in one address byte and compares it with a fixed pattern. One bit of that pattern comes from a strap input, so two such devices can share a bus. When the address matches, the block acknowledges. It then takes any number of command bytes, acknowledges each one, and hands each byte to a downstream register decoder with a one-cycle valid strobe. There is no register pointer: every byte stands on its own.

The bus is never driven high. The block only asserts an open-drain pull-down enable on SDA. It does not support reads, clock stretching, general call or 10-bit addresses. An address byte with the direction bit set counts as a mismatch.

Top module: `i2c_wr_target`

## Requirements
- R1: While reset is asserted, and after it is released until the first START, `sda_oe_o` and `rx_vld_o` are 0 and `rx_byte_o` is 8'h00.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one releases `sda_oe_o` at once. After a STOP, SCL pulses are ignored (no acknowledge, no strobe) until a START.
- R3: The address byte matches only if it equals {1,1,1,1,1,0,S,0} (bit 7 first), where S is the level of `addr_sel_i`. That is 8'hF8 for S=0 and 8'hFA for S=1. A set bit 0 (read) never matches.
- R4: On an address match, `sda_oe_o` rises only after the filtered SCL falls at the end of the eighth pulse. It stays high through the ninth pulse and drops after the ninth pulse's falling edge.
- R5: On an address mismatch, `sda_oe_o` stays 0 and no byte is strobed until the next START. A repeated START in that state starts a fresh address phase.
- R6: Bits are sampled on rising SCL, MSB first. After the eighth bit of each data byte, `rx_vld_o` pulses for exactly one cycle with the byte on `rx_byte_o`, and that byte is acknowledged.
- R7: After a matching address, any number of back-to-back data bytes are each acknowledged and strobed in order until STOP.
- R8: A repeated START in the middle of a byte discards the bits already shifted and restarts the address phase.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks is ignored. It does not shift a bit and is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (resolved bus level) |
| addr_sel_i | input | 1 | Static strap that sets address bit 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| rx_byte_o | output | 8 | Last received command byte |
| rx_vld_o | output | 1 | One-cycle strobe when `rx_byte_o` is new |

## Verification
The bench sweeps all 256 address byte values against the strap. A comparator that ignores the direction bit or the strap bit would acknowledge the wrong bytes there.

Directed cases target the exact edges of the acknowledge window, a repeated START in the middle of a byte, and clocking after a STOP with no START. They also inject glitches on both lines that are shorter than the filter length. The failures these cases catch are:
- An acknowledge that starts one edge early.
- A partial byte that leaks into the next transfer.
- A target that keeps listening after STOP.
- A filter that lets a glitch shift an extra bit or fake a START or STOP.

Back-to-back data bytes with alternating bit patterns check the MSB-first order and that the strobe lasts exactly one cycle.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned CNT_W        = $clog2(BYTE_W + 1);
  // Fixed part of the address byte; bit ADDR_SEL_POS is replaced by the strap.
  localparam logic [BYTE_W-1:0] ADDR_BASE = 8'hF8;
  localparam int unsigned ADDR_SEL_POS = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } rx_state_t;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned LINES       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] filt_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   level_q;
    logic                   level_d;

    // Level moves only once every recent sample agrees.
    always_comb begin
      level_d = level_q;
      if (&hist_q) begin
        level_d = 1'b1;
      end else if (~|hist_q) begin
        level_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q  <= '1;
        hist_q  <= '1;
        level_q <= 1'b1;
      end else begin
        sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        level_q <= level_d;
      end
    end

    assign filt_o[g] = level_q;
  end

endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import i2c_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_vld
);

  rx_state_t         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              oe_q, oe_d;
  logic              vld_q, vld_d;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] addr_exp;

  logic scl_rise, scl_fall, bus_start, bus_stop, byte_full;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign byte_full = (cnt_q == CNT_W'(BYTE_W));

  always_comb begin
    addr_exp               = ADDR_BASE;
    addr_exp[ADDR_SEL_POS] = addr_sel;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    byte_d  = byte_q;
    oe_d    = oe_q;
    vld_d   = 1'b0;
    if (bus_start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      shift_d = '0;
      oe_d    = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && !byte_full) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_f};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            if (state_q == ST_DATA) begin
              oe_d    = 1'b1;
              vld_d   = 1'b1;
              byte_d  = shift_q;
              state_d = ST_DACK;
            end else if (shift_q == addr_exp) begin
              oe_d    = 1'b1;
              state_d = ST_AACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_AACK, ST_DACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      byte_q  <= '0;
      oe_q    <= 1'b0;
      vld_q   <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      byte_q  <= byte_d;
      oe_q    <= oe_d;
      vld_q   <= vld_d;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end
  end

  assign sda_oe  = oe_q;
  assign rx_byte = byte_q;
  assign rx_vld  = vld_q;

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2c_wr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_vld_o
);

  localparam int unsigned LINES = 2;

  logic             rst_sync_n;
  logic [LINES-1:0] filt;
  logic             scl_filt;
  logic             sda_filt;

  i2c_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  i2c_line_filter #(
    .LINES       (LINES),
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw_i  ({sda_i, scl_i}),
    .filt_o (filt)
  );

  assign scl_filt = filt[0];
  assign sda_filt = filt[1];

  i2c_wr_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (scl_filt),
    .sda_f    (sda_filt),
    .addr_sel (addr_sel_i),
    .sda_oe   (sda_oe_o),
    .rx_byte  (rx_byte_o),
    .rx_vld   (rx_vld_o)
  );

endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_f,
  input logic sda_oe,
  input logic rx_vld
);

  // R6
  vld_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

  // R6
  vld_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> (sda_oe && !scl_f));

  // R4
  ack_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && $fell(sda_f)) |=> !sda_oe);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && $rose(sda_f)) |=> (!sda_oe && !rx_vld));

endmodule

bind i2c_wr_target i2c_wr_target_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_f  (scl_filt),
  .sda_f  (sda_filt),
  .sda_oe (sda_oe_o),
  .rx_vld (rx_vld_o)
);

// File: tb/tb_i2c_wr_target.sv
module tb_i2c_wr_target;

  localparam int Q        = 10;
  localparam int FILT_LEN = 3;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda;
  logic       addr_sel;
  logic       sda_line;
  logic       sda_oe_o;
  logic [7:0] rx_byte_o;
  logic       rx_vld_o;

  int checks;
  int errors;
  int ncap;
  int wide;
  bit done;
  logic [7:0] cap [0:63];
  logic vld_prev;

  assign sda_line = m_sda & ~sda_oe_o;

  i2c_wr_target #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .addr_sel_i (addr_sel),
    .sda_oe_o   (sda_oe_o),
    .rx_byte_o  (rx_byte_o),
    .rx_vld_o   (rx_vld_o)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  // Strobe capture and width monitor (R6)
  always @(negedge clk) begin
    if (rx_vld_o) begin
      if (ncap < 64) cap[ncap] = rx_byte_o;
      ncap = ncap + 1;
      if (vld_prev) wide = wide + 1;
    end
    vld_prev = rx_vld_o;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(2 * Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  // Returns ack (oe held across ninth pulse), oe before 8th fall, oe after 9th fall.
  task automatic send_byte(input logic [7:0] b, input bit glitch,
                           output bit ack, output bit oe_early, output bit oe_late);
    bit pre;
    oe_early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 5) begin
        wq(3); m_scl = 1'b1; wq(FILT_LEN - 1); m_scl = 1'b0;
      end
      wq(Q);
      m_scl = 1'b1; wq(Q);
      if (i == 0) oe_early = sda_oe_o;
      if (glitch && i == 7) begin
        m_sda = 1'b0; wq(FILT_LEN - 1); m_sda = b[i];
      end
      wq(Q);
      m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1;
    pre = sda_oe_o;
    wq(Q);
    m_scl = 1'b1; wq(Q);
    ack = pre & sda_oe_o;
    wq(Q);
    m_scl = 1'b0; wq(Q);
    oe_late = sda_oe_o;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit ack, oe_e, oe_l;
    int base;
    logic [7:0] exp_addr;
    logic [7:0] seq [0:4];
    checks = 0; errors = 0; ncap = 0; wide = 0; done = 1'b0; vld_prev = 1'b0;
    m_scl = 1'b1; m_sda = 1'b1; addr_sel = 1'b0; rst_n = 1'b0;
    wq(5);
    // R1 during reset
    chk(sda_oe_o == 1'b0 && rx_vld_o == 1'b0, "R1 oe/vld in reset", {sda_oe_o, rx_vld_o}, 0);
    rst_n = 1'b1;
    wq(10);
    // R1 after release
    chk(sda_oe_o == 1'b0 && rx_vld_o == 1'b0 && rx_byte_o == 8'h00, "R1 idle outputs",
        {sda_oe_o, rx_vld_o, rx_byte_o}, 0);

    // R3 / R5 sweep of every address byte, strap = parity of the byte
    for (int a = 0; a < 256; a++) begin
      addr_sel = ^a[7:0];
      exp_addr = {5'b11111, 1'b0, addr_sel, 1'b0};
      base = ncap;
      bus_start();
      send_byte(a[7:0], 1'b0, ack, oe_e, oe_l);
      bus_stop();
      chk(ack == (a[7:0] == exp_addr), "R3 address sweep ack", ack, a);
      chk(ncap == base, "R5 no strobe on address", ncap - base, 0);
    end

    // R3 / R4 match with strap low, then R6 data byte
    addr_sel = 1'b0;
    base = ncap;
    bus_start();
    send_byte(8'hF8, 1'b0, ack, oe_e, oe_l);
    chk(ack, "R3 ack F8 strap 0", ack, 1);
    chk(!oe_e, "R4 oe not before 8th fall", oe_e, 0);
    chk(!oe_l, "R4 oe released after 9th fall", oe_l, 0);
    send_byte(8'hA5, 1'b0, ack, oe_e, oe_l);
    chk(ack && !oe_e && !oe_l, "R6 data ack window", {ack, oe_e, oe_l}, 3'b100);
    chk(ncap == base + 1, "R6 one strobe", ncap - base, 1);
    chk(cap[base] == 8'hA5, "R6 byte value MSB first", cap[base], 8'hA5);
    bus_stop();

    // R3 cross strap cases
    addr_sel = 1'b1;
    bus_start(); send_byte(8'hF8, 1'b0, ack, oe_e, oe_l); bus_stop();
    chk(!ack, "R3 F8 rejected with strap 1", ack, 0);
    addr_sel = 1'b0;
    bus_start(); send_byte(8'hFA, 1'b0, ack, oe_e, oe_l); bus_stop();
    chk(!ack, "R3 FA rejected with strap 0", ack, 0);

    // R7 burst with strap high
    addr_sel = 1'b1;
    seq[0] = 8'h00; seq[1] = 8'hFF; seq[2] = 8'h3C; seq[3] = 8'h81; seq[4] = 8'h7E;
    base = ncap;
    bus_start();
    send_byte(8'hFA, 1'b0, ack, oe_e, oe_l);
    chk(ack, "R3 ack FA strap 1", ack, 1);
    for (int k = 0; k < 5; k++) begin
      send_byte(seq[k], 1'b0, ack, oe_e, oe_l);
      chk(ack, "R7 burst byte ack", ack, 1);
    end
    bus_stop();
    chk(ncap == base + 5, "R7 burst strobe count", ncap - base, 5);
    for (int k = 0; k < 5; k++)
      chk(cap[base + k] == seq[k], "R7 burst byte order", cap[base + k], seq[k]);

    // R3 / R5 read direction rejected, following byte ignored
    addr_sel = 1'b0;
    base = ncap;
    bus_start();
    send_byte(8'hF9, 1'b0, ack, oe_e, oe_l);
    chk(!ack, "R3 read bit rejected", ack, 0);
    send_byte(8'h55, 1'b0, ack, oe_e, oe_l);
    chk(!ack && ncap == base, "R5 data after mismatch ignored", {ack, ncap - base}, 0);
    // R5 repeated START after mismatch restarts address phase
    bus_start();
    send_byte(8'hF8, 1'b0, ack, oe_e, oe_l);
    chk(ack, "R5 restart after mismatch", ack, 1);
    bus_stop();

    // R2 clocking after STOP without START is ignored
    base = ncap;
    m_scl = 1'b0; wq(Q);
    send_byte(8'hF8, 1'b0, ack, oe_e, oe_l);
    send_byte(8'h11, 1'b0, ack, oe_e, oe_l);
    chk(!ack && ncap == base, "R2 no activity after STOP", {ack, ncap - base}, 0);
    bus_stop();

    // R8 repeated START mid byte discards partial bits
    addr_sel = 1'b1;
    base = ncap;
    bus_start();
    send_byte(8'hFA, 1'b0, ack, oe_e, oe_l);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(8'hFA, 1'b0, ack, oe_e, oe_l);
    chk(ack, "R8 address after repeated START", ack, 1);
    send_byte(8'h5A, 1'b0, ack, oe_e, oe_l);
    bus_stop();
    chk(ncap == base + 1 && cap[base] == 8'h5A, "R8 partial byte discarded",
        cap[base], 8'h5A);

    // R9 short glitches on SCL and SDA
    base = ncap;
    bus_start();
    send_byte(8'hFA, 1'b0, ack, oe_e, oe_l);
    send_byte(8'hC3, 1'b1, ack, oe_e, oe_l);
    chk(ack, "R9 glitched byte acked", ack, 1);
    bus_stop();
    chk(ncap == base + 1 && cap[base] == 8'hC3, "R9 glitches filtered", cap[base], 8'hC3);

    chk(wide == 0, "R6 strobe one cycle wide", wide, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule